// File: doc/BRIEF.md
# Phase Clock Synchronizer

This block produces the switching-cycle timebase for one regulator phase and coordinates it with other phases. A period register, given in ticks of a fast system clock, sets the cycle length. A one-tick `cycle_start_o` strobe marks the leading PWM edge of every cycle. At each enable the block samples a strap and fixes its role until the next enable.

As a master it runs at the programmed period. Half a period after each leading edge it drives a short sync pulse to the other phases, but only while power-good is high. As a slave it runs on its own stretched period. Once power-good is high, each rising edge on the sync input restarts its cycle, which locks it onto the master. If those edges stop arriving, the slave keeps cycling on its own timebase with no jump in phase and drops its lock flag.

Top module: `phase_clock_sync`

## Requirements
- R1: While reset is asserted, and after reset until the first enable, `sync_o`, `cycle_start_o`, `slave_o` and `locked_o` are all 0.
- R2: The role is captured from `role_strap_i` (0 = master, 1 = slave) on the first clock on which `enable_i` is high after being low, and is shown on `slave_o`. Changes to the strap while enabled have no effect. With `enable_i` low, no `cycle_start_o` strobe occurs.
- R3: As master, `cycle_start_o` first pulses in the cycle after enable is captured, then every P ticks, where P = max(`period_i`, MIN_PERIOD). MIN_PERIOD defaults to 16.
- R4: As slave with no accepted sync edge, the strobe repeats every P + floor(P/8) ticks.
- R5: As master, `sync_o` goes high floor(P/2)+1 ticks after the `cycle_start_o` cycle and stays high for exactly PULSE_TICKS ticks (default 4). It is emitted only if `pgood_i` is high at its half-period point.
- R6: A slave never drives `sync_o` high. A master ignores `sync_i`.
- R7: As slave with `pgood_i` high, a rising edge on `sync_i` restarts the cycle. `cycle_start_o` and `locked_o` go high on the third rising clock edge after `sync_i` is first sampled high.
- R8: While `pgood_i` is low, a slave ignores edges on `sync_i` and keeps `locked_o` at 0.
- R9: A locked slave that sees no accepted edge for 2·(P + floor(P/8)) ticks clears `locked_o` exactly that many ticks after its last restart. Its strobe spacing continues unchanged through the fallback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, one tick of the period count |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Run enable; its rising edge latches the role |
| role_strap_i | input | 1 | Role strap: 0 master, 1 slave |
| period_i | input | PERIOD_W | Cycle length in ticks |
| pgood_i | input | 1 | Power-good; gates sync output and sync lock |
| sync_i | input | 1 | External sync input (slave) |
| sync_o | output | 1 | Sync pulse output (master) |
| cycle_start_o | output | 1 | One-tick strobe at each leading PWM edge |
| slave_o | output | 1 | Latched role, 1 = slave |
| locked_o | output | 1 | Slave is tracking external sync edges |

## Verification
The hardest state to reach is the lock-loss boundary of a slave. That needs a slave that has been restarted by a train of accepted edges, with edges spaced shorter than its own stretched period so that no free-run wrap intervenes. The edges must then stop, and the bench must observe the exact tick on which the lock flag clears while the free-run strobes keep their spacing. The bench drives an edge train at the master period, checks the three-tick restart latency on each edge, then stops driving and counts ticks from the last restart strobe to both the unlock and the next strobes.

// File: rtl/phase_sync_pkg.sv
package phase_sync_pkg;
  typedef enum logic {
    ROLE_MASTER = 1'b0,
    ROLE_SLAVE  = 1'b1
  } role_e;
endpackage

// File: rtl/phase_sync_timebase.sv
module phase_sync_timebase #(
  parameter int PERIOD_W   = 12,
  parameter int MIN_PERIOD = 16,
  localparam int CW        = PERIOD_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                slave_i,
  input  logic                restart_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic [CW-1:0]       cnt_o,
  output logic [CW-1:0]       limit_o,
  output logic                start_o
);
  logic [CW-1:0] p_ext, p_eff, cnt_q;

  assign p_ext = CW'(period_i);
  assign p_eff = (p_ext < CW'(MIN_PERIOD)) ? CW'(MIN_PERIOD) : p_ext;
  // slave free-runs slower so that a master edge always arrives first
  assign limit_o = slave_i ? (p_eff + (p_eff >> 3)) : p_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || restart_i) begin
      cnt_q <= '0;
    end else if (cnt_q >= limit_o - CW'(1)) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign cnt_o   = cnt_q;
  assign start_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/phase_sync_edge.sv
module phase_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], sync_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/phase_sync_pulse.sv
module phase_sync_pulse #(
  parameter int CW          = 13,
  parameter int PULSE_TICKS = 4,
  localparam int PCW        = $clog2(PULSE_TICKS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          fire_en_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] limit_i,
  output logic          pulse_o
);
  logic [PCW-1:0] left_q;
  logic           trig;

  assign trig = fire_en_i && (cnt_i == (limit_i >> 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
    end else if (!run_i) begin
      left_q <= '0;
    end else if (trig) begin
      left_q <= PCW'(PULSE_TICKS);
    end else if (left_q != '0) begin
      left_q <= left_q - PCW'(1);
    end
  end

  assign pulse_o = (left_q != '0);
endmodule

// File: rtl/phase_sync_lock.sv
module phase_sync_lock #(
  parameter int CW  = 13,
  localparam int MW = CW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          drop_i,
  input  logic          accept_i,
  input  logic [CW-1:0] limit_i,
  output logic          locked_o
);
  logic [MW-1:0] miss_q, win;
  logic          locked_q;

  assign win = {limit_i, 1'b0} - MW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      miss_q   <= '0;
    end else if (drop_i) begin
      locked_q <= 1'b0;
      miss_q   <= '0;
    end else if (accept_i) begin
      locked_q <= 1'b1;
      miss_q   <= '0;
    end else if (locked_q) begin
      if (miss_q >= win) locked_q <= 1'b0;
      else               miss_q   <= miss_q + MW'(1);
    end
  end

  assign locked_o = locked_q;
endmodule

// File: rtl/phase_clock_sync.sv
module phase_clock_sync
  import phase_sync_pkg::*;
#(
  parameter int PERIOD_W    = 12,
  parameter int MIN_PERIOD  = 16,
  parameter int PULSE_TICKS = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CW         = PERIOD_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enable_i,
  input  logic                role_strap_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                pgood_i,
  input  logic                sync_i,
  output logic                sync_o,
  output logic                cycle_start_o,
  output logic                slave_o,
  output logic                locked_o
);
  logic          run_q;
  role_e         role_q;
  logic          is_slave, rise, accept, fire_en, drop;
  logic [CW-1:0] cnt, limit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      role_q <= ROLE_MASTER;
    end else begin
      run_q <= enable_i;
      if (enable_i && !run_q) role_q <= role_e'(role_strap_i);
    end
  end

  assign is_slave = (role_q == ROLE_SLAVE);
  assign accept   = run_q && is_slave && pgood_i && rise;
  assign fire_en  = run_q && !is_slave && pgood_i;
  assign drop     = !run_q || !is_slave || !pgood_i;

  phase_sync_timebase #(
    .PERIOD_W  (PERIOD_W),
    .MIN_PERIOD(MIN_PERIOD)
  ) u_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_q),
    .slave_i  (is_slave),
    .restart_i(accept),
    .period_i (period_i),
    .cnt_o    (cnt),
    .limit_o  (limit),
    .start_o  (cycle_start_o)
  );

  phase_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sync_i(sync_i),
    .rise_o(rise)
  );

  phase_sync_pulse #(.CW(CW), .PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_q),
    .fire_en_i(fire_en),
    .cnt_i    (cnt),
    .limit_i  (limit),
    .pulse_o  (sync_o)
  );

  phase_sync_lock #(.CW(CW)) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .drop_i  (drop),
    .accept_i(accept),
    .limit_i (limit),
    .locked_o(locked_o)
  );

  assign slave_o = is_slave;
endmodule

// File: rtl/phase_clock_sync_chk.sv
module phase_clock_sync_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic run_q,
  input logic pgood_i,
  input logic sync_o,
  input logic cycle_start_o,
  input logic slave_o,
  input logic locked_o
);
  a_r2_role_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q)) |-> $stable(slave_o));

  a_r3_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slave_o && cycle_start_o) |=> !cycle_start_o);

  a_r5_pulse_needs_pgood: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> $past(pgood_i));

  a_r6_slave_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_o |-> !sync_o);

  a_r7_lock_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> cycle_start_o);

  a_r8_no_lock_without_pgood: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pgood_i |=> !locked_o);
endmodule

bind phase_clock_sync phase_clock_sync_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .run_q        (run_q),
  .pgood_i      (pgood_i),
  .sync_o       (sync_o),
  .cycle_start_o(cycle_start_o),
  .slave_o      (slave_o),
  .locked_o     (locked_o)
);

// File: tb/phase_clock_sync_tb.sv
module phase_clock_sync_tb;
  localparam int PW = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          enable = 1'b0, strap = 1'b0, pgood = 1'b0, sync_in = 1'b0;
  logic [PW-1:0] period = PW'(40);
  logic          sync_out, cstart, slave, locked;
  int total = 0, bad = 0;
  bit done = 1'b0;

  phase_clock_sync #(.PERIOD_W(PW), .MIN_PERIOD(16), .PULSE_TICKS(4), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .role_strap_i(strap),
    .period_i(period), .pgood_i(pgood), .sync_i(sync_in),
    .sync_o(sync_out), .cycle_start_o(cstart), .slave_o(slave), .locked_o(locked)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic next_strobe(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!cstart && n < 2000);
  endtask

  task automatic start(input bit s, input int per, output int first);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    strap = s;
    period = PW'(per);
    enable = 1'b1;
    next_strobe(first);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!sync_out && !cstart && !slave && !locked, "R1 in reset",
          int'({sync_out, cstart, slave, locked}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!sync_out && !cstart && !slave && !locked, "R1 after reset",
          int'({sync_out, cstart, slave, locked}), 0);
  endtask

  task automatic t_master_period();
    int n;
    pgood = 1'b1;
    start(1'b0, 40, n);
    check(n == 1, "R3 first strobe", n, 1);
    next_strobe(n);
    check(n == 40, "R3 period", n, 40);
    next_strobe(n);
    check(n == 40, "R3 period again", n, 40);
  endtask

  task automatic t_master_pulse();
    int d, w;
    next_strobe(d);
    d = 0;
    while (!sync_out && d < 200) begin
      @(negedge clk);
      d++;
    end
    check(d == 21, "R5 sync delay", d, 21);
    w = 0;
    while (sync_out && w < 200) begin
      @(negedge clk);
      w++;
    end
    check(w == 4, "R5 sync width", w, 4);
  endtask

  task automatic t_master_no_pgood();
    int hits = 0;
    pgood = 1'b0;
    repeat (90) begin
      @(negedge clk);
      if (sync_out) hits++;
    end
    check(hits == 0, "R5 no pulse without pgood", hits, 0);
    pgood = 1'b1;
  endtask

  task automatic t_master_ignores_sync();
    int n;
    next_strobe(n);
    repeat (10) @(negedge clk);
    sync_in = 1'b1;
    repeat (5) @(negedge clk);
    sync_in = 1'b0;
    next_strobe(n);
    check(n == 25, "R6 master ignores sync_i", n, 25);
  endtask

  task automatic t_role_latch();
    int n, cnt;
    start(1'b0, 40, n);
    strap = 1'b1;
    next_strobe(n);
    next_strobe(n);
    check(n == 40 && !slave, "R2 strap change ignored", n, 40);
    @(negedge clk);
    enable = 1'b0;
    cnt = 0;
    repeat (100) begin
      @(negedge clk);
      if (cstart) cnt++;
    end
    check(cnt == 0, "R2 no strobe while disabled", cnt, 0);
    start(1'b1, 40, n);
    check(slave == 1'b1, "R2 relatch as slave", int'(slave), 1);
    next_strobe(n);
    check(n == 45, "R4 slave free-run period", n, 45);
    cnt = 0;
    repeat (100) begin
      @(negedge clk);
      if (sync_out) cnt++;
    end
    check(cnt == 0, "R6 slave sync_o quiet", cnt, 0);
  endtask

  task automatic t_slave_no_pgood();
    int n;
    pgood = 1'b0;
    next_strobe(n);
    repeat (10) @(negedge clk);
    sync_in = 1'b1;
    repeat (4) @(negedge clk);
    sync_in = 1'b0;
    next_strobe(n);
    check(n == 31, "R8 edge ignored without pgood", n, 31);
    check(!locked, "R8 not locked", int'(locked), 0);
    pgood = 1'b1;
  endtask

  task automatic t_slave_lock();
    int n;
    next_strobe(n);
    repeat (12) @(negedge clk);
    sync_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!cstart, "R7 no restart before latency", int'(cstart), 0);
    @(negedge clk);
    check(cstart && locked, "R7 restart and lock", int'({cstart, locked}), 3);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      sync_in = 1'b0;
      repeat (36) @(negedge clk);
      sync_in = 1'b1;
      repeat (3) @(negedge clk);
      check(cstart && locked, "R7 tracked edge", int'({cstart, locked}), 3);
    end
    // fallback after edges stop
    @(negedge clk);
    sync_in = 1'b0;
    next_strobe(n);
    check(n == 44, "R9 free-run spacing kept", n + 1, 45);
    repeat (44) @(negedge clk);
    check(locked, "R9 still locked before window", int'(locked), 1);
    @(negedge clk);
    check(!locked, "R9 lock lost at window", int'(locked), 0);
    check(cstart, "R9 strobe uninterrupted", int'(cstart), 1);
  endtask

  task automatic t_clamp();
    int n;
    start(1'b0, 5, n);
    next_strobe(n);
    check(n == 16, "R3 period clamped to minimum", n, 16);
  endtask

  initial begin
    t_reset();
    t_master_period();
    t_master_pulse();
    t_master_no_pgood();
    t_master_ignores_sync();
    t_role_latch();
    t_slave_no_pgood();
    t_slave_lock();
    t_clamp();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule